// File: doc/BRIEF.md
# Floating-Point Exception Recorder and Arithmetic Trap Generator

This block sits beside a floating-point execution pipe. For every completed floating-point or conversion operation it takes the raw exception flags the datapath raised, the trap qualifier encoded in the instruction, a per-exception disable mask and the instruction address. It ORs the flags into a sticky status register, then decides whether an arithmetic trap must be taken. When one is, it produces a trap request carrying an exception summary word and the return address.

Status recording does not depend on the qualifier. Qualifiers only decide which recorded conditions may trap. The underflow-suppress, integer-overflow-enable, inexact-enable and software-completion options each act on their own. A control-register write port lets software load the status bits. The trap request and its summary are registered, so they appear one clock after the operation is presented.

Top module: `fpx_trap_unit`

## Requirements
- R1: Every exception flag of a valid operation, after the denormal adjustment of R8, is ORed into the status register whatever its qualifier. Status bits are cleared only by reset or by a control write.
- R2: `status_o[5:0]` holds one bit per exception: bit 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact, 5 integer overflow. `status_o[6]` is 1 exactly when any of bits 5:0 is 1. The same flag order is used by `op_flags_i`, `trap_mask_i` and `csr_wdata_i`.
- R3: `trap_summary_o[0]` is the software-completion bit. It is 1 on a trap whose qualifier includes software completion (codes 3 to 7), and 0 otherwise. `trap_summary_o[6:1]` lists the exceptions that caused the trap, in the order of R2.
- R4: With software completion, a flag whose `trap_mask_i` bit is 1 cannot cause a trap but is still recorded. Without software completion, the mask has no effect.
- R5: Qualifiers with underflow suppression (codes 1 U, 4 SU, 5 SUI) never trap on underflow. Underflow traps under every other qualifier, and its status bit is set in all cases.
- R6: Inexact can trap only under codes 5 (SUI) and 7 (SVI). Its status bit is set under every qualifier.
- R7: Integer overflow can trap only under the codes with the V option: 2 (V), 6 (SV) and 7 (SVI). Its status bit is set under every qualifier, including code 0.
- R8: When `op_denorm_i` is 1 and the qualifier lacks software completion (codes 0 to 2), the operation raises invalid in place of underflow. Both the status bit and the trap decision use this adjusted flag.
- R9: On a trap, `trap_pc_o` equals the operation's PC plus 4, modulo 2^PC_W. It is 0 when no trap is raised.
- R10: A control write replaces status bits 5:0 with `csr_wdata_i` and takes priority over an operation's update in the same cycle.
- R11: Reset clears the status register and all trap outputs.
- R12: `trap_o` is a one-cycle pulse in the cycle after a valid operation that has at least one trap-enabled flag. Without a valid operation it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | An operation completes this cycle |
| op_flags_i | input | 6 | Raw exception flags of the operation (R2 order) |
| op_denorm_i | input | 1 | An operand of the operation was denormal |
| op_qual_i | input | 3 | Trap qualifier: 0 none, 1 U, 2 V, 3 S, 4 SU, 5 SUI, 6 SV, 7 SVI |
| op_pc_i | input | PC_W | Address of the operation |
| trap_mask_i | input | 6 | Per-exception trap disable, honoured with software completion |
| csr_we_i | input | 1 | Status register write strobe |
| csr_wdata_i | input | 6 | Status register write data |
| status_o | output | 7 | Sticky exception bits plus summary bit 6 |
| trap_o | output | 1 | Arithmetic trap request |
| trap_summary_o | output | 7 | Exception summary: bit 0 software completion, bits 6:1 causes |
| trap_pc_o | output | PC_W | Trap return address |

## Verification
The main sweep runs every qualifier against all 64 flag combinations, with and without a denormal operand, under three disable masks: none, all, and alternating. Qualifier codes are told apart by which flags may trap. The denormal input shows whether invalid replaces underflow only outside software completion. The masks show that the disable bits act only when software completion is present and never reach the status bits. Directed cases add sticky accumulation across operations, a control write colliding with an update, summary-bit behaviour and PC wrap-around.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int unsigned NUM_EXC = 6;
  localparam int unsigned EXC_INV = 0;
  localparam int unsigned EXC_DZE = 1;
  localparam int unsigned EXC_OVF = 2;
  localparam int unsigned EXC_UNF = 3;
  localparam int unsigned EXC_INE = 4;
  localparam int unsigned EXC_IOV = 5;
  localparam int unsigned QUAL_W  = 3;

  typedef struct packed {
    logic sw_compl;
    logic unf_block;
    logic ine_en;
    logic iov_en;
  } fpx_qual_t;
endpackage

// File: rtl/fpx_qual_decode.sv
module fpx_qual_decode
  import fpx_pkg::*;
(
  input  logic [QUAL_W-1:0] qual_i,
  output fpx_qual_t         dec_o
);
  always_comb begin
    dec_o = '0;
    case (qual_i)
      3'd1: dec_o.unf_block = 1'b1;                            // U
      3'd2: dec_o.iov_en    = 1'b1;                            // V
      3'd3: dec_o.sw_compl  = 1'b1;                            // S
      3'd4: begin dec_o.sw_compl = 1'b1; dec_o.unf_block = 1'b1; end
      3'd5: begin dec_o.sw_compl = 1'b1; dec_o.unf_block = 1'b1; dec_o.ine_en = 1'b1; end
      3'd6: begin dec_o.sw_compl = 1'b1; dec_o.iov_en = 1'b1; end
      3'd7: begin dec_o.sw_compl = 1'b1; dec_o.iov_en = 1'b1; dec_o.ine_en = 1'b1; end
      default: dec_o = '0;
    endcase
  end
endmodule

// File: rtl/fpx_flag_adjust.sv
module fpx_flag_adjust
  import fpx_pkg::*;
(
  input  logic [NUM_EXC-1:0] flags_i,
  input  logic               denorm_i,
  input  logic               sw_compl_i,
  output logic [NUM_EXC-1:0] flags_o
);
  // denormal operand without software completion: invalid replaces underflow
  always_comb begin
    flags_o = flags_i;
    if (denorm_i && !sw_compl_i) begin
      flags_o[EXC_UNF] = 1'b0;
      flags_o[EXC_INV] = 1'b1;
    end
  end
endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
  import fpx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_i,
  input  logic [NUM_EXC-1:0] flags_i,
  input  logic               we_i,
  input  logic [NUM_EXC-1:0] wdata_i,
  output logic [NUM_EXC:0]   status_o
);
  logic [NUM_EXC-1:0] sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sts_q <= '0;
    else if (we_i)  sts_q <= wdata_i;
    else if (upd_i) sts_q <= sts_q | flags_i;
  end

  assign status_o = {|sts_q, sts_q};

  assert_sticky_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we_i) |-> ((sts_q & $past(sts_q)) == $past(sts_q)));
  assert_flags_recorded_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(upd_i) && !$past(we_i)) |-> ((sts_q & $past(flags_i)) == $past(flags_i)));
  assert_write_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i) |-> (sts_q == $past(wdata_i)));
endmodule

// File: rtl/fpx_trap_gen.sv
module fpx_trap_gen
  import fpx_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [NUM_EXC-1:0] flags_i,
  input  fpx_qual_t          dec_i,
  input  logic [NUM_EXC-1:0] mask_i,
  input  logic [PC_W-1:0]    pc_i,
  output logic               trap_o,
  output logic [NUM_EXC:0]   summary_o,
  output logic [PC_W-1:0]    pc_o
);
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

  logic [NUM_EXC-1:0] en, cause;
  logic               fire;

  for (genvar i = 0; i < NUM_EXC; i++) begin : g_en
    logic base;
    if (i == EXC_UNF)      begin : g_unf assign base = !dec_i.unf_block; end
    else if (i == EXC_INE) begin : g_ine assign base = dec_i.ine_en;     end
    else if (i == EXC_IOV) begin : g_iov assign base = dec_i.iov_en;     end
    else                   begin : g_fix assign base = 1'b1;             end
    assign en[i] = base && !(dec_i.sw_compl && mask_i[i]);
  end

  assign cause = flags_i & en;
  assign fire  = valid_i && (|cause);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_o    <= 1'b0;
      summary_o <= '0;
      pc_o      <= '0;
    end else begin
      trap_o    <= fire;
      summary_o <= fire ? {cause, dec_i.sw_compl} : '0;
      pc_o      <= fire ? pc_i + PC_STEP : '0;
    end
  end

  assert_trap_has_cause_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (summary_o[NUM_EXC:1] != '0));
  assert_no_trap_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> !trap_o);
  assert_mask_honoured_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && summary_o[0]) |-> ((summary_o[NUM_EXC:1] & $past(mask_i)) == '0));
endmodule

// File: rtl/fpx_trap_unit.sv
module fpx_trap_unit
  import fpx_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               op_valid_i,
  input  logic [5:0]         op_flags_i,
  input  logic               op_denorm_i,
  input  logic [2:0]         op_qual_i,
  input  logic [PC_W-1:0]    op_pc_i,
  input  logic [5:0]         trap_mask_i,
  input  logic               csr_we_i,
  input  logic [5:0]         csr_wdata_i,
  output logic [6:0]         status_o,
  output logic               trap_o,
  output logic [6:0]         trap_summary_o,
  output logic [PC_W-1:0]    trap_pc_o
);
  fpx_qual_t          dec;
  logic [NUM_EXC-1:0] flags_adj;

  fpx_qual_decode u_dec (.qual_i(op_qual_i), .dec_o(dec));

  fpx_flag_adjust u_adj (
    .flags_i(op_flags_i), .denorm_i(op_denorm_i),
    .sw_compl_i(dec.sw_compl), .flags_o(flags_adj)
  );

  fpx_status_reg u_sts (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(op_valid_i), .flags_i(flags_adj),
    .we_i(csr_we_i), .wdata_i(csr_wdata_i), .status_o(status_o)
  );

  fpx_trap_gen #(.PC_W(PC_W)) u_trap (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(op_valid_i), .flags_i(flags_adj),
    .dec_i(dec), .mask_i(trap_mask_i), .pc_i(op_pc_i),
    .trap_o(trap_o), .summary_o(trap_summary_o), .pc_o(trap_pc_o)
  );

  assert_ret_pc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (trap_pc_o == $past(op_pc_i) + PC_W'(4)));
  assert_swc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (trap_summary_o[0] == ($past(op_qual_i) >= 3'd3)));
  assert_ine_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && trap_summary_o[1+EXC_INE]) |-> ($past(op_qual_i) == 3'd5 || $past(op_qual_i) == 3'd7));
  assert_iov_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && trap_summary_o[1+EXC_IOV]) |-> ($past(op_qual_i) inside {3'd2, 3'd6, 3'd7}));
  assert_unf_block_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && trap_summary_o[1+EXC_UNF]) |-> !($past(op_qual_i) inside {3'd1, 3'd4, 3'd5}));
  assert_denorm_inv_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(op_valid_i) && $past(op_denorm_i) && $past(op_qual_i) < 3'd3 && !$past(csr_we_i))
    |-> (status_o[EXC_INV] && trap_o && !trap_summary_o[1+EXC_UNF]));
endmodule

// File: tb/fpx_trap_unit_tb.sv
module fpx_trap_unit_tb;
  localparam int PC_W = 32;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            op_valid_i = 1'b0;
  logic [5:0]      op_flags_i = '0;
  logic            op_denorm_i = 1'b0;
  logic [2:0]      op_qual_i = '0;
  logic [PC_W-1:0] op_pc_i = '0;
  logic [5:0]      trap_mask_i = '0;
  logic            csr_we_i = 1'b0;
  logic [5:0]      csr_wdata_i = '0;
  logic [6:0]      status_o;
  logic            trap_o;
  logic [6:0]      trap_summary_o;
  logic [PC_W-1:0] trap_pc_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  fpx_trap_unit #(.PC_W(PC_W)) u_dut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] m_eff(logic [5:0] f, logic d, logic [2:0] q);
    logic [5:0] e = f;
    if (d && q < 3) begin e[3] = 1'b0; e[0] = 1'b1; end
    return e;
  endfunction

  function automatic logic [5:0] m_cause(logic [5:0] e, logic [2:0] q, logic [5:0] m);
    logic [5:0] en = 6'b000111;
    if (!(q == 1 || q == 4 || q == 5)) en[3] = 1'b1;
    if (q == 5 || q == 7)              en[4] = 1'b1;
    if (q == 2 || q == 6 || q == 7)    en[5] = 1'b1;
    if (q >= 3) en = en & ~m;
    return e & en;
  endfunction

  task automatic clr();
    @(negedge clk_i);
    op_valid_i = 1'b0; csr_we_i = 1'b1; csr_wdata_i = '0;
    @(negedge clk_i);
    csr_we_i = 1'b0;
  endtask

  // presents one operation; returns with outputs from it visible
  task automatic op(logic [2:0] q, logic [5:0] f, logic d, logic [5:0] m, logic [PC_W-1:0] pc);
    op_valid_i = 1'b1; op_qual_i = q; op_flags_i = f; op_denorm_i = d;
    trap_mask_i = m; op_pc_i = pc;
    @(negedge clk_i);
    op_valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] masks [3] = '{6'h00, 6'h3F, 6'h15};
    repeat (2) @(negedge clk_i);
    // R11 reset state
    chk("R11 status", status_o, 0);
    chk("R11 trap", trap_o, 0);
    chk("R11 summary", trap_summary_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R12 idle", trap_o, 0);

    // sweep
    for (int q = 0; q < 8; q++)
      for (int f = 0; f < 64; f++)
        for (int d = 0; d < 2; d++)
          for (int mi = 0; mi < 3; mi++) begin
            logic [5:0] e, c;
            logic [PC_W-1:0] pc;
            pc = 32'h0040_0000 + PC_W'((q * 64 + f) * 8 + d * 4);
            e = m_eff(6'(f), d[0], 3'(q));
            c = m_cause(e, 3'(q), masks[mi]);
            clr();
            op(3'(q), 6'(f), d[0], masks[mi], pc);
            chk("R1 status", status_o, {|e, e});
            chk("R12 trap", trap_o, |c);
            chk("R3 summary", trap_summary_o, (|c) ? {c, q >= 3} : 7'd0);
            chk("R9 pc", trap_pc_o, (|c) ? pc + 4 : 0);
          end

    // R5 underflow suppression
    clr(); op(3'd4, 6'h08, 1'b0, 6'h00, 32'h100);
    chk("R5 SU no trap", trap_o, 0); chk("R5 SU status", status_o, 7'h48);
    clr(); op(3'd0, 6'h08, 1'b0, 6'h00, 32'h100);
    chk("R5 plain traps", trap_summary_o, 7'h10);
    // R6 inexact
    clr(); op(3'd3, 6'h10, 1'b0, 6'h00, 32'h100);
    chk("R6 S no trap", trap_o, 0); chk("R6 status", status_o, 7'h50);
    clr(); op(3'd5, 6'h10, 1'b0, 6'h00, 32'h100);
    chk("R6 SUI summary", trap_summary_o, 7'h21);
    // R7 integer overflow
    clr(); op(3'd0, 6'h20, 1'b0, 6'h00, 32'h100);
    chk("R7 plain no trap", trap_o, 0); chk("R7 status", status_o, 7'h60);
    clr(); op(3'd2, 6'h20, 1'b0, 6'h00, 32'h100);
    chk("R7 V summary", trap_summary_o, 7'h40);
    // R8 denormal
    clr(); op(3'd0, 6'h08, 1'b1, 6'h00, 32'h100);
    chk("R8 summary", trap_summary_o, 7'h02); chk("R8 status", status_o, 7'h41);
    // R4 masked with S, mask ignored without S
    clr(); op(3'd3, 6'h04, 1'b0, 6'h04, 32'h100);
    chk("R4 masked no trap", trap_o, 0); chk("R4 recorded", status_o, 7'h44);
    clr(); op(3'd0, 6'h04, 1'b0, 6'h04, 32'h100);
    chk("R4 mask ignored", trap_summary_o, 7'h08);
    // R3 software completion bit
    clr(); op(3'd3, 6'h01, 1'b0, 6'h00, 32'h100);
    chk("R3 swc", trap_summary_o, 7'h03);
    // R1 sticky accumulation
    clr(); op(3'd0, 6'h01, 1'b0, 6'h00, 32'h100);
    op(3'd5, 6'h02, 1'b0, 6'h00, 32'h104);
    chk("R1 sticky", status_o, 7'h43);
    @(negedge clk_i);
    chk("R1 held", status_o, 7'h43);
    chk("R12 pulse", trap_o, 0);
    // R10 write priority
    csr_we_i = 1'b1; csr_wdata_i = 6'h10;
    op(3'd0, 6'h01, 1'b0, 6'h00, 32'h100);
    csr_we_i = 1'b0;
    chk("R10 write wins", status_o, 7'h50);
    // R2 summary bit
    clr();
    chk("R2 empty", status_o, 7'h00);
    csr_we_i = 1'b1; csr_wdata_i = 6'h20;
    @(negedge clk_i); csr_we_i = 1'b0;
    chk("R2 summary bit", status_o, 7'h60);
    // R9 wrap
    clr(); op(3'd0, 6'h01, 1'b0, 6'h00, 32'hFFFF_FFFC);
    chk("R9 wrap", trap_pc_o, 0); chk("R9 trap", trap_o, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule